// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core from three sources: a falling edge on an external pin, a timer overflow strobe and an analog-to-digital conversion-complete strobe. Each source has its own request flag and its own enable. A single master enable gates all of them. The flags, the enables and the master enable share one 8-bit control register that software can read and write.

Pending requests are examined only at a phase strobe that the core pulses once per instruction cycle. If several requests are pending at that strobe, a fixed priority picks one. The block then raises a call request with that source's vector address and holds both until the core acknowledges. The acknowledge clears the serviced flag and the master enable, so no other interrupt is taken until software sets the enable again. While the core reports that its return stack is full, nothing is dispatched and the requests stay pending.

Top module: `pic_vec_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and `call_req` is low.
- R2: The control register has this layout: bit 0 is the master enable, bits 1/2/3 enable the external, timer and converter sources, bits 4/5/6 are their request flags, and bit 7 reads 0. A write of `reg_wdata` while `reg_wr` is high is visible on `reg_rdata` after the next clock edge.
- R3: `ext_pin` passes through a two-flop synchroniser. A high-to-low transition sets the external flag (bit 4) within four clocks, but only while bit 1 is set and `ext_dir_in` is high. The master enable does not affect this.
- R4: A `tmr_ovf` pulse sets bit 5 and an `adc_done` pulse sets bit 6, whatever the enables are.
- R5: A call is raised only at a clock edge where `phase_stb` is high, the master enable is set, and a source has both its enable and its flag set. The vectors are 0x04 for the external source, 0x08 for the timer and 0x0C for the converter.
- R6: When several sources qualify at the same strobe, the external source wins over the timer, and the timer wins over the converter.
- R7: While `stack_full` is high at a strobe, no call is raised. The request is taken at the first strobe after `stack_full` goes low.
- R8: `call_req` and `call_vec` hold steady until a clock edge with `call_ack` high. That edge drops `call_req`, clears the serviced flag and clears the master enable. The source enables are left as they were.
- R9: A flag stays set while its source, or the master enable, is disabled. Only servicing or a software write of 0 clears it.
- R10: If a hardware set event and a software write of 0 to the same flag occur in the same cycle, the flag ends up set.
- R11: `call_ack` has no effect while `call_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_stb | input | 1 | Instruction-cycle phase strobe; the only point at which requests are sampled |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_dir_in | input | 1 | Port direction bit; high selects input |
| tmr_ovf | input | 1 | Timer overflow strobe |
| adc_done | input | 1 | Conversion-complete strobe |
| stack_full | input | 1 | Core return stack full; holds off dispatch |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| call_req | output | 1 | Call request to the core |
| call_vec | output | 8 | Vector address of the request being raised |
| call_ack | input | 1 | Core acknowledge of the call |

## Verification
On every cycle the assertions check the following. A call holds with a stable vector until it is acknowledged. A call rises only at a strobe with the master enable set and the stack not full. An acknowledge drops the call and the master enable. The vector is always one of the three legal addresses. A flag rises only through a write or its own hardware event, and stays set unless written or serviced. The bench scenarios show what needs ordered stimulus. These are the priority sequence across three successive services, the pin-edge latency through the synchroniser, and the direction-bit gating. They also cover the hold-off while the stack is full and the write-versus-event collision.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC    = 3;
  localparam int REG_W   = 8;
  localparam int VEC_W   = 8;
  localparam int GIE_BIT = 0;
  localparam int EN_LSB  = 1;
  localparam int FLG_LSB = EN_LSB + NSRC;
  localparam int IDX_W   = $clog2(NSRC);

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT = 2'd0,
    SRC_TMR = 2'd1,
    SRC_ADC = 2'd2
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] v;
    v = VEC_W'(idx) + VEC_W'(1);
    return v << 2;
  endfunction
endpackage

// File: rtl/pic_fall_detect.sv
module pic_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES:0] sr_q;
  logic [STAGES:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign fall_o = sr_q[STAGES] & ~sr_q[STAGES-1];
endmodule

// File: rtl/pic_ctrl_reg.sv
module pic_ctrl_reg
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [NSRC-1:0]  hw_set_i,
  input  logic [NSRC-1:0]  svc_clr_i,
  input  logic             gie_clr_i,
  output logic             gie_o,
  output logic [NSRC-1:0]  en_o,
  output logic [NSRC-1:0]  flag_o,
  output logic [REG_W-1:0] rdata_o
);
  logic            gie_q, gie_d;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] flag_q, flag_d;

  always_comb begin
    gie_d = gie_q;
    if (gie_clr_i)  gie_d = 1'b0;
    else if (wr_i)  gie_d = wdata_i[GIE_BIT];
  end

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i[EN_LSB +: NSRC];
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
      always_comb begin
        flag_d[i] = flag_q[i];
        if (svc_clr_i[i])     flag_d[i] = 1'b0;
        if (wr_i)             flag_d[i] = wdata_i[FLG_LSB + i];
        if (hw_set_i[i])      flag_d[i] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[GIE_BIT]          = gie_q;
    rdata_o[EN_LSB +: NSRC]   = en_q;
    rdata_o[FLG_LSB +: NSRC]  = flag_q;
  end

  assign gie_o  = gie_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/pic_dispatch.sv
module pic_dispatch
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_stb_i,
  input  logic             stack_full_i,
  input  logic [NSRC-1:0]  pending_i,
  input  logic             ack_i,
  output logic             call_req_o,
  output logic [VEC_W-1:0] call_vec_o,
  output logic [NSRC-1:0]  svc_clr_o,
  output logic             gie_clr_o
);
  logic             req_q, req_d;
  logic [IDX_W-1:0] src_q, src_d;
  logic [IDX_W-1:0] win_idx;
  logic             take;

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending_i[i]) win_idx = IDX_W'(i);
    end
  end

  assign take = phase_stb_i && !stack_full_i && (|pending_i) && !req_q;

  always_comb begin
    req_d = req_q;
    src_d = src_q;
    if (req_q && ack_i) begin
      req_d = 1'b0;
    end else if (take) begin
      req_d = 1'b1;
      src_d = win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      src_q <= '0;
    end else begin
      req_q <= req_d;
      src_q <= src_d;
    end
  end

  always_comb begin
    svc_clr_o = '0;
    if (req_q && ack_i) svc_clr_o[src_q] = 1'b1;
  end

  assign gie_clr_o  = req_q && ack_i;
  assign call_req_o = req_q;
  assign call_vec_o = req_q ? vec_of(src_q) : '0;
endmodule

// File: rtl/pic_vec_ctrl.sv
module pic_vec_ctrl
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_stb,
  input  logic             ext_pin,
  input  logic             ext_dir_in,
  input  logic             tmr_ovf,
  input  logic             adc_done,
  input  logic             stack_full,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  input  logic             call_ack
);
  logic            ext_fall;
  logic            gie;
  logic [NSRC-1:0] en, flag, hw_set, pending, svc_clr;
  logic            gie_clr;

  pic_fall_detect #(.STAGES(2)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin),
    .fall_o (ext_fall)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[SRC_EXT] = ext_fall && en[SRC_EXT] && ext_dir_in;
    hw_set[SRC_TMR] = tmr_ovf;
    hw_set[SRC_ADC] = adc_done;
  end

  pic_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr),
    .wdata_i   (reg_wdata),
    .hw_set_i  (hw_set),
    .svc_clr_i (svc_clr),
    .gie_clr_i (gie_clr),
    .gie_o     (gie),
    .en_o      (en),
    .flag_o    (flag),
    .rdata_o   (reg_rdata)
  );

  assign pending = {NSRC{gie}} & en & flag;

  pic_dispatch u_disp (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_stb_i  (phase_stb),
    .stack_full_i (stack_full),
    .pending_i    (pending),
    .ack_i        (call_ack),
    .call_req_o   (call_req),
    .call_vec_o   (call_vec),
    .svc_clr_o    (svc_clr),
    .gie_clr_o    (gie_clr)
  );
endmodule

// File: rtl/pic_vec_ctrl_chk.sv
module pic_vec_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_stb,
  input logic       ext_dir_in,
  input logic       tmr_ovf,
  input logic       stack_full,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       call_req,
  input logic [7:0] call_vec,
  input logic       call_ack
);
  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    call_req && !call_ack |=> call_req && $stable(call_vec));

  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    call_req && call_ack |=> !call_req && !reg_rdata[0]);

  assert_raise_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_req) |-> $past(phase_stb && reg_rdata[0]));

  assert_stack_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_req) |-> !$past(stack_full));

  assert_legal_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec == 8'h04 || call_vec == 8'h08 || call_vec == 8'h0C));

  assert_tmr_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[5]) |-> $past(tmr_ovf || reg_wr));

  assert_ext_flag_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[4]) |-> $past(reg_wr || (reg_rdata[1] && ext_dir_in)));

  assert_flag_persists_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5] && !reg_wr && !(call_req && call_ack) |=> reg_rdata[5]);

  assert_ack_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !call_req && call_ack && !reg_wr |=> reg_rdata[0] == $past(reg_rdata[0]));
endmodule

bind pic_vec_ctrl pic_vec_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_stb  (phase_stb),
  .ext_dir_in (ext_dir_in),
  .tmr_ovf    (tmr_ovf),
  .stack_full (stack_full),
  .reg_wr     (reg_wr),
  .reg_rdata  (reg_rdata),
  .call_req   (call_req),
  .call_vec   (call_vec),
  .call_ack   (call_ack)
);

// File: tb/pic_vec_ctrl_tb.sv
module pic_vec_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_stb = 1'b0, ext_pin = 1'b1, ext_dir_in = 1'b0;
  logic       tmr_ovf = 1'b0, adc_done = 1'b0, stack_full = 1'b0;
  logic       reg_wr = 1'b0, call_ack = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, call_vec;
  logic       call_req;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pic_vec_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb), .ext_pin(ext_pin),
    .ext_dir_in(ext_dir_in), .tmr_ovf(tmr_ovf), .adc_done(adc_done),
    .stack_full(stack_full), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .call_req(call_req), .call_vec(call_vec),
    .call_ack(call_ack)
  );

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; cyc(); reg_wr = 1'b0;
  endtask

  task automatic strobe();
    phase_stb = 1'b1; cyc(); phase_stb = 1'b0;
  endtask

  task automatic ack();
    call_ack = 1'b1; cyc(); call_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reg", reg_rdata, 8'h00);
    check("R1 call", {7'd0, call_req}, 8'h00);
  endtask

  task automatic t_regrw();
    wr(8'h0F); check("R2 enables", reg_rdata, 8'h0F);
    wr(8'hF0); check("R2 flags, bit7 zero", reg_rdata, 8'h70);
    wr(8'h00); check("R2 clear", reg_rdata, 8'h00);
  endtask

  task automatic t_ext();
    ext_dir_in = 1'b1;
    wr(8'h02);
    ext_pin = 1'b0; cyc(4);
    check("R3 ext flag set", reg_rdata, 8'h12);
    strobe(); check("R5 no call with master off", {7'd0, call_req}, 8'h00);
    wr(8'h02); ext_pin = 1'b1; cyc(4);
    check("R3 rising edge no flag", reg_rdata, 8'h02);
    ext_dir_in = 1'b0; ext_pin = 1'b0; cyc(4);
    check("R3 output direction blocks", reg_rdata, 8'h02);
    ext_pin = 1'b1; cyc(4); wr(8'h00);
  endtask

  task automatic t_mask();
    wr(8'h01); tmr_ovf = 1'b1; cyc(); tmr_ovf = 1'b0;
    check("R4 timer flag", reg_rdata, 8'h21);
    strobe(); cyc(3);
    check("R9 masked flag held", reg_rdata, 8'h21);
    check("R9 masked no call", {7'd0, call_req}, 8'h00);
    wr(8'h01); check("R9 write zero clears", reg_rdata, 8'h01);
    adc_done = 1'b1; cyc(); adc_done = 1'b0;
    check("R4 adc flag", reg_rdata, 8'h41);
    wr(8'h00);
  endtask

  task automatic t_dispatch();
    wr(8'h05); tmr_ovf = 1'b1; cyc(); tmr_ovf = 1'b0;
    check("R4 flag", reg_rdata, 8'h25);
    cyc(2); check("R5 waits for strobe", {7'd0, call_req}, 8'h00);
    strobe();
    check("R5 call raised", {7'd0, call_req}, 8'h01);
    check("R5 timer vector", call_vec, 8'h08);
    cyc(3);
    check("R8 call held", {7'd0, call_req}, 8'h01);
    check("R8 vector held", call_vec, 8'h08);
    ack();
    check("R8 call dropped", {7'd0, call_req}, 8'h00);
    check("R8 flag and master cleared", reg_rdata, 8'h04);
    wr(8'h00);
  endtask

  task automatic t_prio();
    wr(8'h7F); strobe();
    check("R6 external first", call_vec, 8'h04);
    ack(); check("R8 ext cleared", reg_rdata, 8'h6E);
    wr(8'h6F); strobe();
    check("R6 timer second", call_vec, 8'h08);
    ack(); check("R8 tmr cleared", reg_rdata, 8'h4E);
    wr(8'h4F); strobe();
    check("R6 converter last", call_vec, 8'h0C);
    ack(); check("R8 adc cleared", reg_rdata, 8'h0E);
    wr(8'h00);
  endtask

  task automatic t_stack();
    wr(8'h49); stack_full = 1'b1; strobe();
    check("R7 held off", {7'd0, call_req}, 8'h00);
    check("R7 still pending", reg_rdata, 8'h49);
    stack_full = 1'b0; cyc(2);
    check("R7 waits for strobe", {7'd0, call_req}, 8'h00);
    strobe();
    check("R7 taken", {7'd0, call_req}, 8'h01);
    check("R7 vector", call_vec, 8'h0C);
    ack(); wr(8'h00);
  endtask

  task automatic t_collide();
    wr(8'h20);
    reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1; cyc();
    reg_wr = 1'b0; tmr_ovf = 1'b0;
    check("R10 hw set wins", reg_rdata, 8'h20);
    wr(8'h00);
  endtask

  task automatic t_ack_idle();
    wr(8'h21); ack();
    check("R11 stray ack ignored", reg_rdata, 8'h21);
    check("R11 no call", {7'd0, call_req}, 8'h00);
    wr(8'h00);
  endtask

  initial begin
    cyc(2);
    t_reset();
    rst_n = 1'b1; cyc();
    t_reset();
    t_regrw();
    t_ext();
    t_mask();
    t_dispatch();
    t_prio();
    t_stack();
    t_collide();
    t_ack_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule